// File: doc/BRIEF.md
# Audio Codec Control Register Bank

This block holds the 16-bit control registers that set the output stage of a stereo audio codec. A host reaches them over a simple synchronous bus: a write strobe, a 7-bit register index, 16 bits of write data, and 16 bits of read data that follow the index without a clock delay. Four indices are implemented:

- an identification word that also serves as a soft-reset trigger;
- a master volume word with per-channel attenuation codes and mute bits;
- a serial-configuration word that keeps its value through a soft reset;
- a miscellaneous control word whose only live bit enables split muting.

The block decodes the volume state into per-channel attenuation values in half-dB units and per-channel mute flags for the analog output stage. Attenuation codes that arrive in the wider 6-bit form saturate to the 5-bit maximum. The master mute bit covers both channels unless split muting is enabled. When split muting is enabled, the master mute covers only the left channel and a separate bit mutes the right.

Top module: `codec_ctrl_regs`

## Requirements
- R1: After the hardware reset, index 02h reads 8000h, index 74h reads 0000h and index 76h reads 0000h. Both mute outputs are 1 and both attenuation outputs are 0.
- R2: Index 00h always reads 0090h. Writes to it never change this value.
- R3: A write to index 00h with any data sets index 02h back to 8000h and index 76h back to 0000h, starting at the next clock edge.
- R4: Index 74h stores and returns all 16 written bits. Only the hardware reset clears it. A write to index 00h leaves it unchanged.
- R5: Index 02h layout: bit 15 is the master mute, bits 12:8 the left code, bit 7 the right mute and bits 4:0 the right code. Bits 14:13 and 6:5 read 0.
- R6: A write to 02h with bit 13 set stores the left code as 31. A write with bit 5 set stores the right code as 31. Readback shows the stored 31.
- R7: The right-mute bit is stored as written. While split mute is clear, it reads back 0 and does not affect the outputs.
- R8: Bit 12 of index 76h is the split-mute enable. Every other bit of 76h reads 0.
- R9: With split mute clear, both mute outputs follow the master mute. With split mute set, the left mute output follows the master mute and the right mute output follows the right-mute bit.
- R10: Each attenuation output equals its stored code times 3, in half-dB units: code 31 gives 93, which is 46.5 dB.
- R11: Any index other than 00h, 02h, 74h and 76h reads 0000h. Writes to such an index change no register.
- R12: A read of the index being written in the same cycle returns the old contents. The outputs show the new state from the clock edge that captures the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low hardware reset |
| wr_en_i | input | 1 | Write strobe, sampled on the rising edge |
| addr_i | input | 7 | Register index for both read and write |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i, combinational |
| att_left_o | output | 7 | Left attenuation in 0.5 dB steps |
| att_right_o | output | 7 | Right attenuation in 0.5 dB steps |
| mute_left_o | output | 1 | Left channel mute |
| mute_right_o | output | 1 | Right channel mute |

## Verification
The bench aims at the soft reset and checks that the serial-configuration word survives it. A design that clears every register would lose that word, and one that skips the misc word would leave split mute enabled. The bench writes volume codes with the 6-bit overflow bits set. A design without saturation would read back a small code and drive too little attenuation. It writes the right-mute bit while split mute is clear, then enables split mute. This catches designs that leak the bit to the output or that apply the master mute to the wrong channel. Random writes to unmapped and odd indices, together with reads in the same cycle as a write, catch decode aliasing and write-through read paths.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  localparam int unsigned DW      = 16;
  localparam int unsigned AW      = 7;
  localparam int unsigned CW      = 5;
  localparam int unsigned CODE_MAX = (1 << CW) - 1;
  localparam int unsigned ATT_MAX = 3 * CODE_MAX;
  localparam int unsigned ATT_W   = $clog2(ATT_MAX + 1);

  localparam logic [AW-1:0] IDX_ID   = 7'h00;
  localparam logic [AW-1:0] IDX_VOL  = 7'h02;
  localparam logic [AW-1:0] IDX_SER  = 7'h74;
  localparam logic [AW-1:0] IDX_MISC = 7'h76;

  localparam logic [DW-1:0] ID_WORD = 16'h0090;

  // volume word bit positions
  localparam int unsigned MM_BIT   = 15;
  localparam int unsigned LSAT_BIT = 13;
  localparam int unsigned L_LSB    = 8;
  localparam int unsigned RM_BIT   = 7;
  localparam int unsigned RSAT_BIT = 5;
  localparam int unsigned R_LSB    = 0;

  localparam int unsigned SPLIT_BIT = 12;
  localparam logic [DW-1:0] MISC_MASK = DW'(1) << SPLIT_BIT;

  typedef struct packed {
    logic          mm;
    logic [CW-1:0] lcode;
    logic          rm;
    logic [CW-1:0] rcode;
  } vol_t;

  localparam vol_t VOL_DEFAULT = '{mm: 1'b1, lcode: '0, rm: 1'b0, rcode: '0};
endpackage

// File: rtl/ccr_plain_reg.sv
module ccr_plain_reg #(
  parameter int unsigned  W        = 16,
  parameter logic [W-1:0] RST_VAL  = '0,
  parameter logic [W-1:0] MASK     = '1,
  parameter bit           SOFT_CLR = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic         soft_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  generate
    if (SOFT_CLR) begin : g_soft
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     q <= RST_VAL;
        else if (soft_i) q <= RST_VAL;
        else if (wr_i)   q <= d_i & MASK;
      end

      assert_soft_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        soft_i |=> (q_o == RST_VAL));
    end else begin : g_keep
      logic unused_soft;
      assign unused_soft = soft_i;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   q <= RST_VAL;
        else if (wr_i) q <= d_i & MASK;
      end

      assert_soft_keep_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (soft_i && !wr_i) |=> $stable(q_o));
    end
  endgenerate

  assert_no_write_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !soft_i) |=> $stable(q_o));

  assign q_o = q;
endmodule

// File: rtl/ccr_vol_reg.sv
module ccr_vol_reg
  import ccr_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          soft_i,
  input  logic [DW-1:0] d_i,
  output vol_t          vol_o
);
  vol_t vol_q, vol_d;
  logic unused_bits;
  assign unused_bits = ^{d_i[14], d_i[6]};

  // 6-bit codes with the top bit set saturate to the 5-bit maximum
  always_comb begin
    vol_d.mm    = d_i[MM_BIT];
    vol_d.lcode = d_i[LSAT_BIT] ? '1 : d_i[L_LSB +: CW];
    vol_d.rm    = d_i[RM_BIT];
    vol_d.rcode = d_i[RSAT_BIT] ? '1 : d_i[R_LSB +: CW];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     vol_q <= VOL_DEFAULT;
    else if (soft_i) vol_q <= VOL_DEFAULT;
    else if (wr_i)   vol_q <= vol_d;
  end

  assign vol_o = vol_q;

  assert_left_sat_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !soft_i && d_i[LSAT_BIT]) |=> (vol_o.lcode == CW'(CODE_MAX)));
  assert_right_sat_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !soft_i && d_i[RSAT_BIT]) |=> (vol_o.rcode == CW'(CODE_MAX)));
  assert_vol_soft_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_i |=> (vol_o == VOL_DEFAULT));
endmodule

// File: rtl/ccr_out_decode.sv
module ccr_out_decode
  import ccr_pkg::*;
(
  input  vol_t             vol_i,
  input  logic             split_i,
  output logic [ATT_W-1:0] att_l_o,
  output logic [ATT_W-1:0] att_r_o,
  output logic             mute_l_o,
  output logic             mute_r_o
);
  // code * 3 = code + 2*code, in half-dB units
  assign att_l_o = ATT_W'(vol_i.lcode) + ATT_W'({vol_i.lcode, 1'b0});
  assign att_r_o = ATT_W'(vol_i.rcode) + ATT_W'({vol_i.rcode, 1'b0});

  assign mute_l_o = vol_i.mm;
  assign mute_r_o = split_i ? vol_i.rm : vol_i.mm;

  always_comb begin
    assert_att_range_R10: assert ((att_l_o <= ATT_W'(ATT_MAX)) && (att_r_o <= ATT_W'(ATT_MAX))
                                  && (att_l_o % 3 == 0) && (att_r_o % 3 == 0));
    if (!split_i) begin
      assert_joint_mute_R9: assert (mute_l_o == mute_r_o);
    end
  end
endmodule

// File: rtl/codec_ctrl_regs.sv
module codec_ctrl_regs
  import ccr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic [ATT_W-1:0] att_left_o,
  output logic [ATT_W-1:0] att_right_o,
  output logic             mute_left_o,
  output logic             mute_right_o
);
  logic          soft_rst;
  logic          wr_vol, wr_ser, wr_misc;
  vol_t          vol;
  logic [DW-1:0] ser_q, misc_q;
  logic          split;

  assign soft_rst = wr_en_i && (addr_i == IDX_ID);
  assign wr_vol   = wr_en_i && (addr_i == IDX_VOL);
  assign wr_ser   = wr_en_i && (addr_i == IDX_SER);
  assign wr_misc  = wr_en_i && (addr_i == IDX_MISC);

  ccr_vol_reg u_vol (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_vol),
    .soft_i (soft_rst),
    .d_i    (wdata_i),
    .vol_o  (vol)
  );

  ccr_plain_reg #(.W(DW), .RST_VAL('0), .MASK('1), .SOFT_CLR(1'b0)) u_ser (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_ser),
    .soft_i (soft_rst),
    .d_i    (wdata_i),
    .q_o    (ser_q)
  );

  ccr_plain_reg #(.W(DW), .RST_VAL('0), .MASK(MISC_MASK), .SOFT_CLR(1'b1)) u_misc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_misc),
    .soft_i (soft_rst),
    .d_i    (wdata_i),
    .q_o    (misc_q)
  );

  assign split = misc_q[SPLIT_BIT];

  ccr_out_decode u_dec (
    .vol_i    (vol),
    .split_i  (split),
    .att_l_o  (att_left_o),
    .att_r_o  (att_right_o),
    .mute_l_o (mute_left_o),
    .mute_r_o (mute_right_o)
  );

  // right mute is hidden unless split mute is on
  always_comb begin
    unique case (addr_i)
      IDX_ID:   rdata_o = ID_WORD;
      IDX_VOL:  rdata_o = {vol.mm, 2'b00, vol.lcode, vol.rm & split, 2'b00, vol.rcode};
      IDX_SER:  rdata_o = ser_q;
      IDX_MISC: rdata_o = misc_q;
      default:  rdata_o = '0;
    endcase
  end

  assert_id_read_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == IDX_ID) |-> (rdata_o == ID_WORD));
  assert_split_only_bit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (misc_q & ~MISC_MASK) == '0);
  assert_rm_hidden_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!split && addr_i == IDX_VOL) |-> !rdata_o[RM_BIT]);
  assert_left_mute_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_vol |=> (mute_left_o == $past(wdata_i[MM_BIT])));
endmodule

// File: tb/sim_codec_ctrl_regs.sv
module sim_codec_ctrl_regs;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [6:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic [6:0]  att_left_o, att_right_o;
  logic        mute_left_o, mute_right_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // bench model
  bit       m_mm, m_rm, m_split;
  bit [4:0] m_l, m_r;
  bit [15:0] m_ser;

  always #10 clk_i = ~clk_i;

  codec_ctrl_regs u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .att_left_o(att_left_o),
    .att_right_o(att_right_o), .mute_left_o(mute_left_o), .mute_right_o(mute_right_o)
  );

  function automatic bit [15:0] exp_read(bit [6:0] a);
    case (a)
      7'h00:   return 16'h0090;
      7'h02:   return {m_mm, 2'b00, m_l, m_rm & m_split, 2'b00, m_r};
      7'h74:   return m_ser;
      7'h76:   return {3'b000, m_split, 12'h000};
      default: return 16'h0000;
    endcase
  endfunction

  function automatic string tag_for(bit [6:0] a);
    case (a)
      7'h00:   return "R2";
      7'h02:   return "R5";
      7'h74:   return "R4";
      7'h76:   return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_mm = 1'b1; m_l = '0; m_rm = 1'b0; m_r = '0; m_split = 1'b0;
  endtask

  task automatic model_write(bit [6:0] a, bit [15:0] d);
    case (a)
      7'h00: model_reset();
      7'h02: begin
        m_mm = d[15];
        m_l  = d[13] ? 5'h1f : d[12:8];
        m_rm = d[7];
        m_r  = d[5] ? 5'h1f : d[4:0];
      end
      7'h74: m_ser = d;
      7'h76: m_split = d[12];
      default: ;
    endcase
  endtask

  task automatic do_read(bit [6:0] a, string req);
    @(negedge clk_i);
    wr_en_i = 1'b0;
    addr_i  = a;
    #1;
    check(req, rdata_o, exp_read(a));
  endtask

  task automatic check_outs(string req);
    check({req, "/R10 att_left"}, att_left_o, 3 * m_l);
    check({req, "/R10 att_right"}, att_right_o, 3 * m_r);
    check({req, "/R9 mute_left"}, mute_left_o, m_mm);
    check({req, "/R9 mute_right"}, mute_right_o, m_split ? m_rm : m_mm);
  endtask

  // R12: same-cycle read returns old contents
  task automatic do_write(bit [6:0] a, bit [15:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1;
    addr_i  = a;
    wdata_i = d;
    #1;
    check("R12 read during write", rdata_o, exp_read(a));
    @(posedge clk_i);
    model_write(a, d);
    @(negedge clk_i);
    wr_en_i = 1'b0;
    #1;
    check_outs("R12");
  endtask

  task automatic read_all(string req);
    do_read(7'h00, req);
    do_read(7'h02, req);
    do_read(7'h74, req);
    do_read(7'h76, req);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk_i);
      cyc++;
      if (cyc > 150000) begin
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd20250611));
    model_reset();
    m_ser = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    read_all("R1");
    #1 check_outs("R1");

    // R6 saturation of 6-bit codes
    do_write(7'h02, 16'h2025);
    do_read(7'h02, "R6 saturate");
    check("R10 max att", att_left_o, 93);

    // R7 right mute hidden while split clear
    do_write(7'h02, 16'h0A83);
    do_read(7'h02, "R7 rm hidden");
    #1 check("R7 right not muted", mute_right_o, 0);

    // R8 split bit, others masked; R7 stored rm revealed
    do_write(7'h76, 16'hFFFF);
    do_read(7'h76, "R8 split only");
    do_read(7'h02, "R7 rm revealed");
    #1 check("R9 split right mute", mute_right_o, 1);
    check("R9 split left unmuted", mute_left_o, 0);

    // R9 master mute only left with split
    do_write(7'h02, 16'h8000);
    #1 check("R9 left only muted", {mute_left_o, mute_right_o}, 2'b10);

    // R3 / R4 soft reset keeps serial config
    do_write(7'h74, 16'hA5C3);
    do_write(7'h02, 16'h1F1F);
    do_write(7'h00, 16'h1234);
    do_read(7'h74, "R4 kept");
    do_read(7'h02, "R3 vol default");
    do_read(7'h76, "R3 misc default");
    do_read(7'h00, "R2 id after write");

    // R11 unmapped writes ignored
    do_write(7'h04, 16'hFFFF);
    do_write(7'h03, 16'hFFFF);
    do_write(7'h75, 16'h0000);
    do_read(7'h04, "R11 unmapped");
    do_read(7'h03, "R11 odd");
    read_all("R11 untouched");

    // random mix
    for (int i = 0; i < 400; i++) begin
      bit [6:0] a;
      int sel = $urandom_range(0, 9);
      case (sel)
        0:       a = 7'h00;
        1, 2, 3: a = 7'h02;
        4:       a = 7'h74;
        5, 6:    a = 7'h76;
        default: a = 7'($urandom);
      endcase
      do_write(a, 16'($urandom));
      do_read(a, tag_for(a));
      do_read(7'($urandom), "R11 random read");
      if (i % 8 == 0) read_all("R5 random");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule